// File: doc/BRIEF.md
# ADC Result Limit Monitor

This block watches a stream of signed ADC conversion results and records three kinds of violation. A result above a programmable upper bound is one. A result below a programmable lower bound is another. The third is a step between two consecutive results whose magnitude exceeds a programmable slew limit. Each violation sets a sticky bit in a status word. A bit stays set until software writes a 1 to it through the clear port. A single registered interrupt line reports whether any enabled check holds a set flag.

Each check has its own enable. The slew check depends on a remembered previous sample, which a two-state tracker manages. State `TRK_EMPTY` means no usable previous sample exists. State `TRK_ARMED` means the stored sample may be compared against. The tracker makes two transitions. The `prime` transition goes from `TRK_EMPTY` to `TRK_ARMED` when a valid result arrives while the slew check is enabled; that result is only stored and is not compared. The `disarm` transition goes from `TRK_ARMED` to `TRK_EMPTY` in any cycle where the slew check is disabled. The previous-sample register captures every valid result, whatever the state.

Top module: `adc_limit_monitor`

## Requirements
- R1: After reset, `status` is 8'h00 and `irq` is 0.
- R2: A valid result that is strictly greater than `lim_hi` (signed 16-bit) sets `status[5]` when `chk_en[1]` is 1. A result equal to `lim_hi` does not set it.
- R3: A valid result that is strictly less than `lim_lo` (signed 16-bit) sets `status[4]` when `chk_en[0]` is 1. A result equal to `lim_lo` does not set it.
- R4: When the tracker is armed and `chk_en[2]` is 1, a valid result sets `status[6]` if the absolute difference from the previous valid result is strictly greater than `lim_step`. `lim_step` is unsigned 16-bit. A difference equal to `lim_step` sets nothing.
- R5: The first valid result after reset, or after any cycle with `chk_en[2]` at 0, never sets `status[6]`.
- R6: A set flag stays set until it is cleared, whatever later results arrive.
- R7: A 1 in `clr_mask` at bit 4, 5 or 6 clears the matching flag at the next clock edge, and a 0 leaves it unchanged. If a clear and a new violation of the same flag occur in the same cycle, the flag ends set.
- R8: A check whose enable bit is 0 never sets its flag.
- R9: `irq` is a register that is updated at the same edge as the flags. It equals the OR of `status[6:4]` ANDed with `chk_en[2:0]`.
- R10: Bits 7 and 3..0 of `status` are always 0.
- R11: The slew difference is exact over the full 16-bit range. A step from -32768 to 32767 is a difference of 65535. It sets the flag when `lim_step` is 65534 and does not set it when `lim_step` is 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result-valid strobe |
| res_data | input | 16 | Signed conversion result |
| lim_hi | input | 16 | Signed upper bound |
| lim_lo | input | 16 | Signed lower bound |
| lim_step | input | 16 | Unsigned slew limit |
| chk_en | input | 3 | Check enables: bit0 lower, bit1 upper, bit2 slew |
| clr_mask | input | 8 | Write-1-to-clear mask in status bit positions |
| status | output | 8 | Sticky flags: bit4 lower, bit5 upper, bit6 slew |
| irq | output | 1 | Registered combined interrupt |

## Verification
The situations hardest to reach from the ports involve the slew tracker. One is re-priming after the slew enable drops for a single cycle and the next result carries a large step that must be ignored. The other is a clear that coincides with a fresh violation of the same flag. The bench sweeps all eight enable combinations. It feeds a scrambled value sequence that crosses both bounds and the slew limit, and it pulses clears on a fixed cadence so that they land on violating samples. A software model tracks the previous sample and the armed state arithmetically. Directed steps then cover exact-equality boundaries and the full-range step at both extreme slew limits.

// File: rtl/adc_lim_pkg.sv
package adc_lim_pkg;
    localparam int unsigned STAT_W  = 8;
    localparam int unsigned N_CHK   = 3;
    localparam int unsigned CHK_LO  = 0;
    localparam int unsigned CHK_HI  = 1;
    localparam int unsigned CHK_STP = 2;
    localparam int unsigned BIT_LO  = 4;
    localparam int unsigned BIT_HI  = 5;
    localparam int unsigned BIT_STP = 6;

    typedef enum logic {
        TRK_EMPTY = 1'b0,
        TRK_ARMED = 1'b1
    } trk_state_e;
endpackage

// File: rtl/adc_lim_cmp.sv
module adc_lim_cmp #(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] prev,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] step,
    output logic          over,
    output logic          under,
    output logic          jump
);
    localparam int unsigned XW = DW + 1;

    logic [XW-1:0] diff;
    logic [XW-1:0] mag;

    always_comb begin
        over  = $signed(cur) > $signed(hi);
        under = $signed(cur) < $signed(lo);
        diff  = {cur[DW-1], cur} - {prev[DW-1], prev};
        mag   = diff[XW-1] ? (~diff + 1'b1) : diff;
        jump  = mag > {1'b0, step};
    end
endmodule

// File: rtl/adc_lim_track.sv
module adc_lim_track
    import adc_lim_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [DW-1:0] data,
    input  logic          stp_en,
    output logic [DW-1:0] prev,
    output logic          armed
);
    trk_state_e state_q, state_d;
    logic [DW-1:0] prev_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_EMPTY: if (stp_en && valid) state_d = TRK_ARMED;
            TRK_ARMED: if (!stp_en)         state_d = TRK_EMPTY;
            default:                        state_d = TRK_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_EMPTY;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            if (valid) prev_q <= data;
        end
    end

    always_comb begin
        armed = (state_q == TRK_ARMED);
        prev  = prev_q;
    end

    // R5: a cycle with the slew check disabled leaves the tracker unarmed
    a_r5_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        !stp_en |=> !armed);
endmodule

// File: rtl/adc_lim_flags.sv
module adc_lim_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] flags_q, flags_d;
    logic         irq_q;

    always_comb flags_d = (flags_q & ~clr) | hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            irq_q   <= |(flags_d & en);
        end
    end

    always_comb begin
        flags = flags_q;
        irq   = irq_q;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R6: a set flag with no clear stays set
        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            flags_q[i] && !clr[i] |=> flags_q[i]);
        // R7: a clear without a new hit empties the flag
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] && !hit[i] |=> !flags_q[i]);
        // R8: a disabled check cannot raise its flag
        a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] && !flags_q[i] |=> !flags_q[i]);
    end
endmodule

// File: rtl/adc_limit_monitor.sv
module adc_limit_monitor
    import adc_lim_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DW-1:0]     res_data,
    input  logic [DW-1:0]     lim_hi,
    input  logic [DW-1:0]     lim_lo,
    input  logic [DW-1:0]     lim_step,
    input  logic [N_CHK-1:0]  chk_en,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [DW-1:0]    prev;
    logic             armed;
    logic             over, under, jump;
    logic [N_CHK-1:0] hit, clr_bits, flags;

    adc_lim_track #(.DW(DW)) trk_i (
        .clk(clk), .rst_n(rst_n), .valid(res_valid), .data(res_data),
        .stp_en(chk_en[CHK_STP]), .prev(prev), .armed(armed)
    );

    adc_lim_cmp #(.DW(DW)) cmp_i (
        .cur(res_data), .prev(prev), .hi(lim_hi), .lo(lim_lo),
        .step(lim_step), .over(over), .under(under), .jump(jump)
    );

    always_comb begin
        hit[CHK_LO]       = res_valid && chk_en[CHK_LO] && under;
        hit[CHK_HI]       = res_valid && chk_en[CHK_HI] && over;
        hit[CHK_STP]      = res_valid && chk_en[CHK_STP] && armed && jump;
        clr_bits[CHK_LO]  = clr_mask[BIT_LO];
        clr_bits[CHK_HI]  = clr_mask[BIT_HI];
        clr_bits[CHK_STP] = clr_mask[BIT_STP];
    end

    adc_lim_flags #(.N(N_CHK)) flg_i (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr_bits), .en(chk_en),
        .flags(flags), .irq(irq)
    );

    always_comb begin
        status          = '0;
        status[BIT_LO]  = flags[CHK_LO];
        status[BIT_HI]  = flags[CHK_HI];
        status[BIT_STP] = flags[CHK_STP];
    end

    // R2: an enabled over-bound result is visible after the edge
    a_r2_over: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && chk_en[CHK_HI] && ($signed(res_data) > $signed(lim_hi))
        |=> status[BIT_HI]);
    // R3: an enabled under-bound result is visible after the edge
    a_r3_under: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && chk_en[CHK_LO] && ($signed(res_data) < $signed(lim_lo))
        |=> status[BIT_LO]);
    // R5: an unarmed tracker never feeds a slew hit
    a_r5_prime: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !hit[CHK_STP]);
    // R9: a raised interrupt is backed by an enabled set flag
    a_r9_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> |({status[BIT_STP], status[BIT_HI], status[BIT_LO]} & $past(chk_en)));
endmodule

// File: tb/adc_limit_monitor_tb_top.sv
`timescale 1ns/1ps
module adc_limit_monitor_tb_top;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic [15:0] lim_hi = '0, lim_lo = '0, lim_step = '0;
    logic [2:0]  chk_en = '0;
    logic [7:0]  clr_mask = '0;
    logic [7:0]  status;
    logic        irq;

    int n_run = 0, n_fail = 0;

    int       prev_m = 0;
    bit       primed_m = 0;
    bit [2:0] flags_m = '0;
    bit       irq_m = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_limit_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_step(lim_step), .chk_en(chk_en),
        .clr_mask(clr_mask), .status(status), .irq(irq)
    );

    task automatic check(input string tag);
        logic [7:0] exp_s;
        exp_s = {1'b0, flags_m, 4'b0};
        n_run++;
        if (status !== exp_s || irq !== irq_m) begin
            n_fail++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     tag, status, irq, exp_s, irq_m);
        end
    endtask

    task automatic step(input bit v, input int d, input logic [7:0] clr, input string tag);
        int  diff, mag;
        bit  lo_v, hi_v, st_v;
        bit [2:0] cb;
        res_valid = v;
        res_data  = 16'(d);
        clr_mask  = clr;
        @(posedge clk);
        diff = d - prev_m;
        mag  = (diff < 0) ? -diff : diff;
        lo_v = v && chk_en[0] && (d < int'($signed(lim_lo)));
        hi_v = v && chk_en[1] && (d > int'($signed(lim_hi)));
        st_v = v && chk_en[2] && primed_m && (mag > int'({16'b0, lim_step}));
        cb   = {clr[6], clr[5], clr[4]};
        flags_m = (flags_m & ~cb) | {st_v, hi_v, lo_v};
        irq_m   = |(flags_m & chk_en);
        if (!chk_en[2]) primed_m = 0;
        else if (v) primed_m = 1;
        if (v) prev_m = d;
        @(negedge clk);
        res_valid = 1'b0;
        clr_mask  = '0;
        check(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        lim_hi = 16'sd20; lim_lo = -16'sd20; lim_step = 16'd15;
        chk_en = 3'b111;
        step(1, 100, 8'h00, "R5 first sample primes only");

        // near-exhaustive sweep over every enable combination
        for (int e = 0; e < 8; e++) begin
            chk_en = 3'(e);
            for (int k = 0; k < 60; k++) begin
                step(1, ((k * 37 + e * 11) % 97) - 48, (k % 5 == 0) ? 8'h70 : 8'h00,
                     "R2 R3 R4 R6 R7 R8 R9 R10 sweep");
            end
        end

        // equality boundaries
        chk_en = 3'b111;
        step(0, 0, 8'h70, "R7 clear all");
        step(1, 20, 8'h00, "R2 equal to upper bound");
        step(1, 21, 8'h00, "R2 above upper bound");
        step(1, -20, 8'h70, "R3 equal to lower bound after clear");
        step(1, -21, 8'h00, "R3 below lower bound");
        step(1, -6, 8'h70, "R4 step equal to limit");
        step(1, 10, 8'h00, "R4 step above limit");
        step(1, 10, 8'h00, "R6 flags hold without clear");
        step(1, 10, 8'h20, "R7 single-bit clear");
        step(1, 30, 8'h20, "R7 clear and new hit together");

        // re-prime after a one-cycle disable
        step(0, 0, 8'h70, "R7 clear all");
        chk_en = 3'b011;
        step(0, 0, 8'h00, "R5 slew disabled");
        chk_en = 3'b111;
        step(1, -15, 8'h00, "R5 first sample after re-enable");
        step(1, 15, 8'h00, "R4 slew hit after re-prime");
        chk_en = 3'b011;
        step(1, -15, 8'h00, "R8 R9 disabled slew masks irq");

        // full-range step
        chk_en = 3'b100; lim_hi = 16'h7fff; lim_lo = 16'h8000;
        lim_step = 16'd65534;
        step(0, 0, 8'h70, "R7 clear all");
        step(1, -32768, 8'h00, "R11 prime at minimum");
        step(1, 32767, 8'h00, "R11 full step over 65534");
        lim_step = 16'd65535;
        step(1, -32768, 8'h70, "R11 full step equal 65535");
        step(1, 32767, 8'h00, "R11 full step equal 65535 again");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule